// File: doc/BRIEF.md
# Dual Reload Timer with Shared Prescaler

The block has two independent 16-bit timer channels. Both run from one common time base, which is a strobe made by dividing the system clock by twenty. Each channel has a down-counter and a reload register. While its enable bit is set, a channel's counter steps down by one on every time-base strobe. When the counter arrives at zero, the channel raises a sticky status flag. On the next strobe it refills itself from its reload register. A channel can present its flag as an interrupt request.

Only channel 1 can drive a waveform output. A two-bit output mode selects the action taken each time channel 1 arrives at zero: hold, toggle, drive low or drive high. Any mode other than hold claims the external pin, which it shares with a high address line. The block does not multiplex the pad. It only reports which function the pin should carry.

Software reaches all state through a small word-wide register port with the map given below. A flag is cleared by a two-step read: first read the status register while the flag is set, then read that channel's counter.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset, every counter, every reload register, the control register and the status register read 0, `timerOut` is 0, `pinSelTimer` is 0 and `irq` is 0.
- R2: The time base is a free-running modulo-20 counter that is cleared by reset. It strobes once every 20 clocks, so an enabled counter read twice 20 clocks apart differs by exactly 1 (when no zero or reload falls in between).
- R3: On a strobe, an enabled channel holding a non-zero count decrements by one. A disabled channel holds its count.
- R4: A decrement that lands on zero sets that channel's flag. On the next strobe, a channel holding zero loads its reload value. A reload value of 0 keeps the counter at 0 and never sets the flag.
- R5: `irq[n]` is 1 exactly when flag n and interrupt-enable n are both set.
- R6: Reading the status register while flag n is set arms channel n. A later read of counter n then clears flag n and disarms the channel. Reading counter n while the channel is not armed leaves the flag set. A zero event in the same cycle as the clear keeps the flag set.
- R7: Output modes in control bits [5:4] are 0 hold, 1 toggle, 2 drive low and 3 drive high. The mode acts on `timerOut` only in the cycle in which channel 1 arrives at zero. Channel 0 never affects `timerOut`.
- R8: `pinSelTimer` is 1 whenever control bits [5:4] are non-zero, and 0 when both bits are 0 (the address function).
- R9: Register map at `addr`: 0 = counter 0, 1 = reload 0, 2 = counter 1, 3 = reload 1, 4 = control (bit0 enable 0, bit1 enable 1, bit2 interrupt-enable 0, bit3 interrupt-enable 1, bits[5:4] output mode), 5 = status (bit0 flag 0, bit1 flag 1, read-only). Any other address reads 0. `rdData` follows `addr` in the same cycle. A counter write takes effect at the next edge and overrides a strobe in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 3 | Register select |
| wrEn | input | 1 | Write strobe for the selected register |
| rdEn | input | 1 | Read strobe, used for the flag-clear sequence |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Contents of the selected register |
| irq | output | 2 | Interrupt request per channel |
| timerOut | output | 1 | Channel 1 waveform output |
| pinSelTimer | output | 1 | 1 when the shared pin carries the timer output |

## Verification
The assertions assume that `wrEn` and `rdEn` are never high together, and that no write targets a read-only or unmapped address. The bench drives at most one access per cycle, and it writes only mapped registers. Counter writes are swept across every prescaler phase, so that some of them fall on a strobe. The flag-clear checks run with channel 0 disabled, so that no new zero event can interfere with the two-step read.

// File: rtl/drt_pkg.sv
package drt_pkg;
  localparam int unsigned NUM_CH    = 2;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned OUT_CH    = 1;
  localparam int unsigned CTL_W     = 6;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd5;

  typedef enum logic [1:0] {
    OUT_HOLD   = 2'd0,
    OUT_TOGGLE = 2'd1,
    OUT_LOW    = 2'd2,
    OUT_HIGH   = 2'd3
  } outMode_t;

  typedef struct packed {
    logic [NUM_CH-1:0] cntWr;
    logic [NUM_CH-1:0] rldWr;
    logic [NUM_CH-1:0] run;
  } dpStrobe_t;
endpackage

// File: rtl/drt_prescaler.sv
module drt_prescaler #(
  parameter int unsigned DIV = 20
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else if (phase == LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + PW'(1);
    end
  end

  assign tick = (phase == LAST);
endmodule

// File: rtl/drt_datapath.sv
module drt_datapath
  import drt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         tick,
  input  dpStrobe_t                    strobe,
  input  logic [CNT_W-1:0]             wrData,
  output logic [NUM_CH-1:0][CNT_W-1:0] count,
  output logic [NUM_CH-1:0][CNT_W-1:0] reloadVal,
  output logic [NUM_CH-1:0]            zeroHit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CNT_W-1:0] cntQ;
    logic [CNT_W-1:0] rldQ;
    logic             stepNow;

    assign stepNow = tick && strobe.run[ch] && !strobe.cntWr[ch];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ <= '0;
      end else if (strobe.cntWr[ch]) begin
        cntQ <= wrData;
      end else if (stepNow) begin
        if (cntQ == '0) begin
          cntQ <= rldQ;
        end else begin
          cntQ <= cntQ - ONE;
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rldQ <= '0;
      end else if (strobe.rldWr[ch]) begin
        rldQ <= wrData;
      end
    end

    assign zeroHit[ch]   = stepNow && (cntQ == ONE);
    assign count[ch]     = cntQ;
    assign reloadVal[ch] = rldQ;
  end
endmodule

// File: rtl/drt_ctrl.sv
module drt_ctrl
  import drt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         wrEn,
  input  logic                         rdEn,
  input  logic [CTL_W-1:0]             ctlData,
  input  logic [NUM_CH-1:0][CNT_W-1:0] count,
  input  logic [NUM_CH-1:0][CNT_W-1:0] reloadVal,
  input  logic [NUM_CH-1:0]            zeroHit,
  output dpStrobe_t                    strobe,
  output logic [CNT_W-1:0]             rdData,
  output logic [NUM_CH-1:0]            flags,
  output logic [NUM_CH-1:0]            irq,
  output logic                         timerOut,
  output logic                         pinSelTimer
);
  logic [NUM_CH-1:0] enQ;
  logic [NUM_CH-1:0] ieQ;
  outMode_t          outCtlQ;
  logic              toutQ;
  logic [NUM_CH-1:0] hitCnt;
  logic [NUM_CH-1:0] hitRld;
  logic              hitCtrl;
  logic              hitStat;

  always_comb begin
    for (int ch = 0; ch < NUM_CH; ch++) begin
      hitCnt[ch] = (addr == ADDR_W'(2 * ch));
      hitRld[ch] = (addr == ADDR_W'(2 * ch + 1));
    end
    hitCtrl = (addr == ADDR_CTRL);
    hitStat = (addr == ADDR_STAT);
  end

  always_comb begin
    strobe.cntWr = wrEn ? hitCnt : '0;
    strobe.rldWr = wrEn ? hitRld : '0;
    strobe.run   = enQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ     <= '0;
      ieQ     <= '0;
      outCtlQ <= OUT_HOLD;
    end else if (wrEn && hitCtrl) begin
      enQ     <= ctlData[1:0];
      ieQ     <= ctlData[3:2];
      outCtlQ <= outMode_t'(ctlData[5:4]);
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_flag
    logic flagQ;
    logic armQ;
    logic clrNow;
    logic armNow;

    assign clrNow = rdEn && hitCnt[ch] && armQ;
    assign armNow = rdEn && hitStat && flagQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagQ <= 1'b0;
        armQ  <= 1'b0;
      end else begin
        if (zeroHit[ch]) begin
          flagQ <= 1'b1;
        end else if (clrNow) begin
          flagQ <= 1'b0;
        end
        if (clrNow) begin
          armQ <= 1'b0;
        end else if (armNow) begin
          armQ <= 1'b1;
        end
      end
    end

    assign flags[ch] = flagQ;
  end

  assign irq = flags & ieQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toutQ <= 1'b0;
    end else if (zeroHit[OUT_CH]) begin
      unique case (outCtlQ)
        OUT_TOGGLE: toutQ <= ~toutQ;
        OUT_LOW:    toutQ <= 1'b0;
        OUT_HIGH:   toutQ <= 1'b1;
        default:    toutQ <= toutQ;
      endcase
    end
  end

  assign timerOut    = toutQ;
  assign pinSelTimer = (outCtlQ != OUT_HOLD);

  always_comb begin
    rdData = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (hitCnt[ch]) rdData = count[ch];
      if (hitRld[ch]) rdData = reloadVal[ch];
    end
    if (hitCtrl) rdData = CNT_W'({outCtlQ, ieQ, enQ});
    if (hitStat) rdData = CNT_W'(flags);
  end
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import drt_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PRESCALE = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic [NUM_CH-1:0] irq,
  output logic              timerOut,
  output logic              pinSelTimer
);
  logic                         tick;
  dpStrobe_t                    strobe;
  logic [NUM_CH-1:0][CNT_W-1:0] count;
  logic [NUM_CH-1:0][CNT_W-1:0] reloadVal;
  logic [NUM_CH-1:0]            zeroHit;
  logic [NUM_CH-1:0]            flags;

  drt_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk  (clk),
    .rstN (rstN),
    .tick (tick)
  );

  drt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .strobe    (strobe),
    .wrData    (wrData),
    .count     (count),
    .reloadVal (reloadVal),
    .zeroHit   (zeroHit)
  );

  drt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .addr        (addr),
    .wrEn        (wrEn),
    .rdEn        (rdEn),
    .ctlData     (wrData[CTL_W-1:0]),
    .count       (count),
    .reloadVal   (reloadVal),
    .zeroHit     (zeroHit),
    .strobe      (strobe),
    .rdData      (rdData),
    .flags       (flags),
    .irq         (irq),
    .timerOut    (timerOut),
    .pinSelTimer (pinSelTimer)
  );
endmodule

// File: rtl/drt_checker.sv
module drt_checker
  import drt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         tick,
  input dpStrobe_t                    strobe,
  input logic [NUM_CH-1:0][CNT_W-1:0] count,
  input logic [NUM_CH-1:0][CNT_W-1:0] reloadVal,
  input logic [NUM_CH-1:0]            zeroHit,
  input logic [NUM_CH-1:0]            flags,
  input logic                         timerOut
);
  // R2: strobes are never back to back
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  // R7: the output moves only on a channel 1 zero event
  a_r7_out_stable: assert property (@(posedge clk) disable iff (!rstN)
    !zeroHit[OUT_CH] |=> $stable(timerOut));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    // R3: one step down per strobe
    a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
      (tick && strobe.run[ch] && !strobe.cntWr[ch] && count[ch] != '0)
      |=> count[ch] == $past(count[ch]) - CNT_W'(1));

    // R3: no strobe, no write, no change
    a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!(tick && strobe.run[ch]) && !strobe.cntWr[ch]) |=> $stable(count[ch]));

    // R4: reload from zero
    a_r4_reload: assert property (@(posedge clk) disable iff (!rstN)
      (tick && strobe.run[ch] && !strobe.cntWr[ch] && count[ch] == '0)
      |=> count[ch] == $past(reloadVal[ch]));

    // R4: zero event leaves the flag set
    a_r4_flag_set: assert property (@(posedge clk) disable iff (!rstN)
      zeroHit[ch] |=> flags[ch]);

    // R9: reload register changes only through a write
    a_r9_reload_hold: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.rldWr[ch] |=> $stable(reloadVal[ch]));
  end
endmodule

bind dual_reload_timer drt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tick      (tick),
  .strobe    (strobe),
  .count     (count),
  .reloadVal (reloadVal),
  .zeroHit   (zeroHit),
  .flags     (flags),
  .timerOut  (timerOut)
);

// File: tb/dual_reload_timer_tb.sv
`timescale 1ns/1ps
module dual_reload_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [1:0]  irq;
  logic        timerOut;
  logic        pinSelTimer;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  dual_reload_timer u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .irq(irq), .timerOut(timerOut),
    .pinSelTimer(pinSelTimer)
  );

  // behavioural reference model
  int unsigned mPre = 0;
  int unsigned mCnt [2] = '{0, 0};
  int unsigned mRld [2] = '{0, 0};
  bit          mFlg [2] = '{0, 0};
  bit          mArm [2] = '{0, 0};
  int unsigned mCtl = 0;
  bit          mOut = 0;

  always @(posedge clk) begin
    bit tk;
    bit zh [2];
    bit clr, sa;
    int unsigned mode;
    cyc++;
    if (!rstN) begin
      mPre = 0; mCtl = 0; mOut = 0;
      for (int c = 0; c < 2; c++) begin
        mCnt[c] = 0; mRld[c] = 0; mFlg[c] = 0; mArm[c] = 0;
      end
    end else begin
      tk = (mPre == 19);
      mPre = tk ? 0 : mPre + 1;
      mode = (mCtl >> 4) & 3;
      for (int c = 0; c < 2; c++) begin
        zh[c] = 0;
        if (wrEn && addr == 3'(2 * c)) mCnt[c] = wrData;
        else if (tk && mCtl[c]) begin
          if (mCnt[c] == 0) mCnt[c] = mRld[c];
          else begin
            mCnt[c] = mCnt[c] - 1;
            if (mCnt[c] == 0) zh[c] = 1;
          end
        end
        if (wrEn && addr == 3'(2 * c + 1)) mRld[c] = wrData;
        clr = rdEn && addr == 3'(2 * c) && mArm[c];
        sa  = rdEn && addr == 3'd5 && mFlg[c];
        if (zh[c]) mFlg[c] = 1;
        else if (clr) mFlg[c] = 0;
        if (clr) mArm[c] = 0;
        else if (sa) mArm[c] = 1;
      end
      if (zh[1]) begin
        if (mode == 1) mOut = ~mOut;
        else if (mode == 2) mOut = 0;
        else if (mode == 3) mOut = 1;
      end
      if (wrEn && addr == 3'd4) mCtl = wrData & 16'h3F;
    end
  end

  function automatic int unsigned expRd(logic [2:0] a);
    case (a)
      3'd0: return mCnt[0];
      3'd1: return mRld[0];
      3'd2: return mCnt[1];
      3'd3: return mRld[1];
      3'd4: return mCtl;
      3'd5: return {30'd0, mFlg[1], mFlg[0]};
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      if (addr == 3'd0 || addr == 3'd2) chk("R3 count", rdData, expRd(addr));
      else if (addr == 3'd5)             chk("R6 status", rdData, expRd(addr));
      else                               chk("R9 register", rdData, expRd(addr));
      chk("R5 irq", irq, {(mFlg[1] && mCtl[3]), (mFlg[0] && mCtl[2])});
      chk("R7 timerOut", timerOut, mOut);
      chk("R8 pinSelTimer", pinSelTimer, ((mCtl >> 4) & 3) != 0);
    end
  end

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1; rdEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; wrEn = 1'b0; rdEn = 1'b1;
    #2 d = rdData;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrEn = 1'b0; rdEn = 1'b0; addr = 3'(cyc % 6);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v, v2;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reset register", v, 0);
    end
    chk("R1 reset timerOut", timerOut, 0);
    chk("R1 reset pinSelTimer", pinSelTimer, 0);
    chk("R1 reset irq", irq, 0);

    // configure both channels, toggle mode
    wr(3'd1, 16'd5); wr(3'd0, 16'd5);
    wr(3'd3, 16'd3); wr(3'd2, 16'd3);
    wr(3'd4, 16'h1F);
    idle(1);
    chk("R8 pin taken in toggle mode", pinSelTimer, 1);
    idle(300);

    // R6 clear sequence with channel 0 stopped
    wr(3'd4, 16'h1E);
    idle(1);
    chk("R5 irq0 with flag and enable", irq[0], 1);
    rd(3'd0, v);
    rd(3'd5, v);
    chk("R6 unarmed counter read keeps flag0", v[0], 1);
    rd(3'd0, v);
    rd(3'd5, v);
    chk("R6 armed counter read clears flag0", v[0], 0);
    idle(1);
    chk("R5 irq0 drops after clear", irq[0], 0);

    // R3 disabled channel holds
    rd(3'd0, v);
    idle(39);
    rd(3'd0, v2);
    chk("R3 disabled counter holds", v2, v);

    // R7 output modes
    wr(3'd4, 16'h2E);
    idle(100);
    chk("R7 drive low mode", timerOut, 0);
    wr(3'd4, 16'h3E);
    idle(100);
    chk("R7 drive high mode", timerOut, 1);
    wr(3'd4, 16'h0E);
    idle(1);
    chk("R8 hold mode gives pin to address", pinSelTimer, 0);
    idle(100);
    chk("R7 hold mode keeps output", timerOut, 1);

    // R4 reload value zero: channel 0 only
    wr(3'd1, 16'd0); wr(3'd0, 16'd0);
    wr(3'd4, 16'h05);
    idle(100);
    rd(3'd0, v);
    chk("R4 zero reload stays zero", v, 0);
    rd(3'd5, v);
    chk("R4 zero reload sets no flag", v[0], 0);

    // R2 strobe spacing
    wr(3'd1, 16'd2000); wr(3'd0, 16'd1000);
    idle(3);
    rd(3'd0, v);
    idle(19);
    rd(3'd0, v2);
    chk("R2 one step per 20 clocks", v - v2, 1);
    idle(19);
    rd(3'd0, v2);
    chk("R2 two steps per 40 clocks", v - v2, 2);

    // R9 counter writes swept over every prescaler phase
    for (int k = 0; k < 22; k++) begin
      wr(3'd0, 16'(500 + k));
      idle(k + 1);
    end
    rd(3'd1, v);
    chk("R9 reload readback", v, 2000);

    // short reloads on both channels with toggle
    wr(3'd1, 16'd1); wr(3'd0, 16'd1); wr(3'd3, 16'd1); wr(3'd2, 16'd2);
    wr(3'd4, 16'h1F);
    idle(400);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule